// File: doc/BRIEF.md
# Firmware Bus Cycle Header Decoder

This block monitors a 4-bit multiplexed firmware-memory bus qualified by an active-low frame strobe and decodes the header of each memory cycle. It accepts two header framings on the same wires. The first is the LPC memory framing: a start nibble, a cycle-type nibble and a 32-bit address. The second is the firmware-hub framing: the start nibble gives the direction, the next nibble selects one of sixteen devices and a 28-bit address follows. The start nibble tells the two framings apart. Each framing has its own enable input, so one instance can act as an LPC-only, hub-only or dual-mode target.

When a header completes, the block gives a one-cycle valid pulse together with the direction, the framing, the select nibble and the address. These fields are held until the next accepted header. A header that the block does not serve gives a one-cycle ignored pulse instead. Such headers include unknown starts, non-memory cycle types, a disabled framing and a device select that does not match. Data, turnaround and sync phases are left to downstream logic.

Top module: `fwbus_hdr_decoder`

## Requirements
- R1: A hub start nibble of 4'hD (read) or 4'hE (write), followed by a select nibble and 7 address nibbles, raises `hdr_valid` on the clock that samples the last address nibble. `hdr_fwh`=1 and `hdr_write` gives the direction.
- R2: A hub header is accepted only when its select nibble equals `dev_sel`, and `hdr_sel` reports that nibble. A mismatch raises `hdr_ignored` instead of `hdr_valid`.
- R3: An LPC start nibble of 4'h0 followed by a type nibble 010x (read) or 011x (write) is accepted with `hdr_fwh`=0. Bit 0 of the type nibble has no effect.
- R4: Address nibbles arrive most significant first. An LPC header carries 8 nibbles that form all 32 bits. A hub header carries 7 nibbles in `hdr_addr[27:0]`, and `hdr_addr[31:28]` reads 0.
- R5: When `lpc_en` is 0, an LPC header gives `hdr_ignored` and no `hdr_valid`. When `fwh_en` is 0, the same holds for hub headers. The other framing stays unaffected.
- R6: A start nibble other than 0, D or E, or an LPC type nibble whose upper two bits are not 01, raises `hdr_ignored` on the clock after the start. The block then waits for a new frame.
- R7: If `fw_frame_n` goes low during the address phase, the header is dropped with no pulse, and the nibble on that clock is taken as a new start.
- R8: If the frame strobe is held low for several clocks, only the nibble on its last low clock counts as the start.
- R9: After reset all outputs are 0. `hdr_valid` and `hdr_ignored` are never high together, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fw_frame_n | input | 1 | Active-low frame strobe |
| fw_nib | input | 4 | Multiplexed command/address nibble |
| lpc_en | input | 1 | Accept LPC memory headers |
| fwh_en | input | 1 | Accept hub memory headers |
| dev_sel | input | 4 | Device select that hub headers must match |
| hdr_valid | output | 1 | One-cycle pulse: accepted header |
| hdr_ignored | output | 1 | One-cycle pulse: header not served |
| hdr_fwh | output | 1 | Accepted header used the hub framing |
| hdr_write | output | 1 | Accepted header is a write |
| hdr_sel | output | 4 | Select nibble of an accepted hub header |
| hdr_addr | output | 32 | Decoded address |

## Verification
The assertions check the following on every cycle. The two pulses never overlap, and a valid pulse never repeats on the next cycle. A valid pulse never follows a clock on which the strobe was low. An accepted hub header always matches `dev_sel` and has a zero top nibble. An accepted header always belongs to an enabled framing. Only the scenarios can show that the address nibbles land in the right order and that the direction decode is correct. They also cover the choice of start nibble in a long frame, and which malformed or mismatched headers give an ignored pulse rather than silence.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_ADDR} fwb_state_e;
  typedef enum logic [1:0] {KIND_NONE, KIND_LPC, KIND_FWH} hdr_kind_e;

  localparam logic [3:0] START_LPC    = 4'h0;
  localparam logic [3:0] START_FWH_RD = 4'hD;
  localparam logic [3:0] START_FWH_WR = 4'hE;
  localparam logic [1:0] LPC_MEM_TYPE = 2'b01;
endpackage

// File: rtl/fwb_hdr_classify.sv
module fwb_hdr_classify
  import fwb_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] start_nib,
  input  logic [NIB_W-1:0] type_nib,
  input  logic             lpc_en,
  input  logic             fwh_en,
  input  logic [NIB_W-1:0] dev_sel,
  output hdr_kind_e        kind,
  output logic             is_write,
  output logic             sel_ok
);
  always_comb begin
    kind     = KIND_NONE;
    is_write = 1'b0;
    sel_ok   = 1'b1;
    if (start_nib == START_LPC) begin
      if (lpc_en && (type_nib[NIB_W-1:NIB_W-2] == LPC_MEM_TYPE)) begin
        kind     = KIND_LPC;
        is_write = type_nib[1];
      end
    end else if ((start_nib == START_FWH_RD) || (start_nib == START_FWH_WR)) begin
      if (fwh_en) begin
        kind     = KIND_FWH;
        is_write = (start_nib == START_FWH_WR);
        sel_ok   = (type_nib == dev_sel);
      end
    end
  end
endmodule

// File: rtl/fwb_nib_counter.sv
module fwb_nib_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);

  p_cnt_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !last);
endmodule

// File: rtl/fwb_addr_shift.sv
module fwb_addr_shift #(
  parameter int NIB_W   = 4,
  parameter int MAX_NIB = 8,
  localparam int ADDR_W = NIB_W * MAX_NIB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic [NIB_W-1:0]  nib,
  output logic [ADDR_W-1:0] addr_next
);
  logic [ADDR_W-1:0] addr_q;

  assign addr_next = {addr_q[ADDR_W-NIB_W-1:0], nib};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (clr)   addr_q <= '0;
    else if (shift) addr_q <= addr_next;
  end
endmodule

// File: rtl/fwbus_hdr_decoder.sv
module fwbus_hdr_decoder
  import fwb_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int LPC_NIB = 8,
  parameter int FWH_NIB = 7,
  localparam int ADDR_W = NIB_W * LPC_NIB,
  localparam int CNT_W  = $clog2(LPC_NIB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_frame_n,
  input  logic [NIB_W-1:0]  fw_nib,
  input  logic              lpc_en,
  input  logic              fwh_en,
  input  logic [NIB_W-1:0]  dev_sel,
  output logic              hdr_valid,
  output logic              hdr_ignored,
  output logic              hdr_fwh,
  output logic              hdr_write,
  output logic [NIB_W-1:0]  hdr_sel,
  output logic [ADDR_W-1:0] hdr_addr
);
  fwb_state_e        state_q, state_d;
  logic [NIB_W-1:0]  start_q, start_d;
  logic              start_en;
  logic              fwh_q, wr_q, selok_q;
  logic [NIB_W-1:0]  sel_q;
  logic              hdr_cap;

  hdr_kind_e         c_kind;
  logic              c_write, c_selok;

  logic              cnt_load, cnt_dec, cnt_last;
  logic [CNT_W-1:0]  cnt_val;
  logic              sh_clr, sh_en;
  logic [ADDR_W-1:0] addr_nx;

  logic              valid_d, ign_d;

  fwb_hdr_classify #(.NIB_W(NIB_W)) u_cls (
    .start_nib (start_q),
    .type_nib  (fw_nib),
    .lpc_en    (lpc_en),
    .fwh_en    (fwh_en),
    .dev_sel   (dev_sel),
    .kind      (c_kind),
    .is_write  (c_write),
    .sel_ok    (c_selok)
  );

  fwb_nib_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .last     (cnt_last)
  );

  fwb_addr_shift #(.NIB_W(NIB_W), .MAX_NIB(LPC_NIB)) u_sh (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sh_clr),
    .shift     (sh_en),
    .nib       (fw_nib),
    .addr_next (addr_nx)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    start_d  = start_q;
    start_en = 1'b0;
    hdr_cap  = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    cnt_val  = CNT_W'(LPC_NIB - 1);
    sh_clr   = 1'b0;
    sh_en    = 1'b0;
    valid_d  = 1'b0;
    ign_d    = 1'b0;
    if (!fw_frame_n) begin
      // any strobe clock (re)starts the header; last one wins
      state_d  = ST_START;
      start_d  = fw_nib;
      start_en = 1'b1;
    end else begin
      unique case (state_q)
        ST_START: begin
          if (c_kind == KIND_NONE) begin
            ign_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            hdr_cap  = 1'b1;
            cnt_load = 1'b1;
            sh_clr   = 1'b1;
            cnt_val  = (c_kind == KIND_FWH) ? CNT_W'(FWH_NIB - 1)
                                            : CNT_W'(LPC_NIB - 1);
            state_d  = ST_ADDR;
          end
        end
        ST_ADDR: begin
          sh_en = 1'b1;
          if (cnt_last) begin
            state_d = ST_IDLE;
            valid_d = selok_q;
            ign_d   = !selok_q;
          end else begin
            cnt_dec = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= '0;
      fwh_q   <= 1'b0;
      wr_q    <= 1'b0;
      selok_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_en) start_q <= start_d;
      if (hdr_cap) begin
        fwh_q   <= (c_kind == KIND_FWH);
        wr_q    <= c_write;
        selok_q <= c_selok;
        sel_q   <= (c_kind == KIND_FWH) ? fw_nib : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_valid   <= 1'b0;
      hdr_ignored <= 1'b0;
      hdr_fwh     <= 1'b0;
      hdr_write   <= 1'b0;
      hdr_sel     <= '0;
      hdr_addr    <= '0;
    end else begin
      hdr_valid   <= valid_d;
      hdr_ignored <= ign_d;
      if (valid_d) begin
        hdr_fwh   <= fwh_q;
        hdr_write <= wr_q;
        hdr_sel   <= sel_q;
        hdr_addr  <= addr_nx;
      end
    end
  end

  // Assertions
  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_valid && hdr_ignored));
  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !hdr_valid);
  p_ign_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ignored |=> !hdr_ignored);
  p_abort_no_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fw_frame_n |=> !hdr_valid);
  p_sel_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_fwh) |-> (hdr_sel == dev_sel));
  p_fwh_addr_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_fwh) |-> (hdr_addr[ADDR_W-1:NIB_W*FWH_NIB] == '0));
  p_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> (hdr_fwh ? fwh_en : lpc_en));
endmodule

// File: tb/fwbus_hdr_decoder_test.sv
`timescale 1ns/1ps
module fwbus_hdr_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fw_frame_n;
  logic [3:0]  fw_nib;
  logic        lpc_en, fwh_en;
  logic [3:0]  dev_sel;
  logic        hdr_valid, hdr_ignored, hdr_fwh, hdr_write;
  logic [3:0]  hdr_sel;
  logic [31:0] hdr_addr;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic        ign;
    logic        fwh;
    logic        wr;
    logic [3:0]  sel;
    logic [31:0] addr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  fwbus_hdr_decoder uut (
    .clk(clk), .rst_n(rst_n), .fw_frame_n(fw_frame_n), .fw_nib(fw_nib),
    .lpc_en(lpc_en), .fwh_en(fwh_en), .dev_sel(dev_sel),
    .hdr_valid(hdr_valid), .hdr_ignored(hdr_ignored), .hdr_fwh(hdr_fwh),
    .hdr_write(hdr_write), .hdr_sel(hdr_sel), .hdr_addr(hdr_addr)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic exp_ok(input logic fwh, input logic wr, input logic [3:0] sel,
                        input logic [31:0] addr, input string tag);
    exp_t e;
    e.ign = 1'b0; e.fwh = fwh; e.wr = wr; e.sel = sel; e.addr = addr; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic exp_ign(input string tag);
    exp_t e;
    e.ign = 1'b1; e.fwh = 1'b0; e.wr = 1'b0; e.sel = '0; e.addr = '0; e.tag = tag;
    sb.push_back(e);
  endtask

  // pre: extra strobe-low clocks before the real start; idle: clocks after
  task automatic drive_hdr(input logic [3:0] start, input logic [3:0] second,
                           input int nnib, input logic [31:0] addr,
                           input int pre, input int idle);
    for (int i = 0; i < pre; i++) begin
      @(negedge clk); fw_frame_n = 1'b0; fw_nib = ~start ^ 4'(i);
    end
    @(negedge clk); fw_frame_n = 1'b0; fw_nib = start;
    @(negedge clk); fw_frame_n = 1'b1; fw_nib = second;
    for (int i = 0; i < nnib; i++) begin
      @(negedge clk); fw_nib = addr[(nnib-1-i)*4 +: 4];
    end
    for (int i = 0; i < idle; i++) begin
      @(negedge clk); fw_frame_n = 1'b1; fw_nib = 4'hF;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && (hdr_valid || hdr_ignored)) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R7 unexpected pulse: valid=%0b ignored=%0b expected none",
                 hdr_valid, hdr_ignored);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.ign) begin
          if (!hdr_ignored || hdr_valid) begin
            n_bad++;
            $display("FAIL %s: valid=%0b ignored=%0b expected ignored",
                     e.tag, hdr_valid, hdr_ignored);
          end
        end else if (!hdr_valid || hdr_ignored || hdr_fwh !== e.fwh ||
                     hdr_write !== e.wr || hdr_sel !== e.sel || hdr_addr !== e.addr) begin
          n_bad++;
          $display("FAIL %s: v=%0b i=%0b fwh=%0b wr=%0b sel=%h addr=%h expected v=1 fwh=%0b wr=%0b sel=%h addr=%h",
                   e.tag, hdr_valid, hdr_ignored, hdr_fwh, hdr_write, hdr_sel, hdr_addr,
                   e.fwh, e.wr, e.sel, e.addr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; fw_frame_n = 1'b1; fw_nib = 4'hF;
    lpc_en = 1'b1; fwh_en = 1'b1; dev_sel = 4'h5;
    repeat (3) @(negedge clk);
    n_chk++;
    if (hdr_valid || hdr_ignored || hdr_fwh || hdr_write || hdr_sel != 0 || hdr_addr != 0) begin
      n_bad++;
      $display("FAIL R9 reset state: v=%0b i=%0b addr=%h expected all zero",
               hdr_valid, hdr_ignored, hdr_addr);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 / R4: hub read and write
    exp_ok(1, 0, 4'h5, 32'h00ABCDEF, "R1 hub read");
    drive_hdr(4'hD, 4'h5, 7, 32'h00ABCDEF, 0, 2);
    exp_ok(1, 1, 4'h5, 32'h0FFFFFFF, "R4 hub write full addr");
    drive_hdr(4'hE, 4'h5, 7, 32'h0FFFFFFF, 0, 2);
    // R2: select mismatch
    exp_ign("R2 select mismatch");
    drive_hdr(4'hD, 4'h3, 7, 32'h01234567, 0, 2);
    // R3 / R4: LPC read and write, reserved bit set
    exp_ok(0, 0, 4'h0, 32'h12345678, "R3 lpc read");
    drive_hdr(4'h0, 4'h4, 8, 32'h12345678, 0, 2);
    exp_ok(0, 1, 4'h0, 32'hFFFF0001, "R3 lpc write reserved bit");
    drive_hdr(4'h0, 4'h7, 8, 32'hFFFF0001, 0, 2);
    exp_ok(0, 0, 4'h0, 32'h80000000, "R4 lpc msb first");
    drive_hdr(4'h0, 4'h5, 8, 32'h80000000, 0, 2);
    // R6: non-memory type and unknown start
    exp_ign("R6 io cycle type");
    drive_hdr(4'h0, 4'h1, 0, 32'h0, 0, 2);
    exp_ign("R6 unknown start");
    drive_hdr(4'h5, 4'h4, 0, 32'h0, 0, 2);
    // R5: LPC disabled
    lpc_en = 1'b0;
    exp_ign("R5 lpc disabled");
    drive_hdr(4'h0, 4'h4, 8, 32'h11112222, 0, 2);
    exp_ok(1, 0, 4'h5, 32'h00112233, "R5 hub still served");
    drive_hdr(4'hD, 4'h5, 7, 32'h00112233, 0, 2);
    // R5: hub disabled
    lpc_en = 1'b1; fwh_en = 1'b0;
    exp_ign("R5 hub disabled");
    drive_hdr(4'hE, 4'h5, 7, 32'h00445566, 0, 2);
    exp_ok(0, 1, 4'h0, 32'hCAFE0042, "R5 lpc still served");
    drive_hdr(4'h0, 4'h6, 8, 32'hCAFE0042, 0, 2);
    fwh_en = 1'b1;
    // R7: abort mid-address then new LPC header
    exp_ok(0, 0, 4'h0, 32'hA5A55A5A, "R7 abort then new header");
    drive_hdr(4'hD, 4'h5, 3, 32'h00000ABC, 0, 0);
    drive_hdr(4'h0, 4'h4, 8, 32'hA5A55A5A, 0, 2);
    // R8: long frame, last low nibble is the start
    exp_ok(0, 1, 4'h0, 32'h0BADF00D, "R8 long frame");
    drive_hdr(4'h0, 4'h6, 8, 32'h0BADF00D, 3, 2);
    exp_ok(1, 1, 4'h5, 32'h07654321, "R8 long frame hub");
    drive_hdr(4'hE, 4'h5, 7, 32'h07654321, 2, 2);
    // R2: new select value
    dev_sel = 4'hA;
    exp_ok(1, 0, 4'hA, 32'h0000F00F, "R2 select match new id");
    drive_hdr(4'hD, 4'hA, 7, 32'h0000F00F, 0, 2);
    // R9: back-to-back headers with no idle
    exp_ok(0, 0, 4'h0, 32'h01010101, "R9 back to back a");
    exp_ok(0, 1, 4'h0, 32'h20202020, "R9 back to back b");
    drive_hdr(4'h0, 4'h4, 8, 32'h01010101, 0, 0);
    drive_hdr(4'h0, 4'h6, 8, 32'h20202020, 0, 4);

    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R1 missing pulses: %0d left, expected 0", sb.size());
    end
    summary();
    $finish;
  end
endmodule